// File: doc/BRIEF.md
# Packed Lane Logical Right Shifter

This block shifts a packed SIMD operand to the right with zero fill. The 128-bit destination operand is split into lanes of 16, 32 or 64 bits, and every lane moves right by one shared count. Bits never cross from one lane into the next. The element size and the source of the count come from an opcode byte. The count is either an 8-bit immediate, zero-extended, or the low 64 bits of a register operand. When the count is larger than the highest valid bit index of a lane, the whole active operand is cleared.

A mode input selects either a 64-bit or a 128-bit datapath. In 64-bit mode only the low half is processed, and the high half of the destination passes through unchanged. The result is registered, so it appears one cycle after the input. A valid flag travels alongside it. An opcode byte that does not name a supported form raises an illegal flag and returns the destination unmodified. No status flags are produced.

Top module: `simd_lsr_unit`

## Requirements
- R1: The opcode byte selects the form. 0x71 and 0xD1 select 16-bit lanes, 0x72 and 0xD2 select 32-bit lanes, 0x73 and 0xD3 select 64-bit lanes. High nibble 0x7 takes the count from `imm`, and high nibble 0xD takes it from `cnt_src`.
- R2: Each lane is shifted right by the count and its vacated upper bits become 0. No bit of one lane reaches another lane.
- R3: If the count is above 15 for 16-bit lanes, above 31 for 32-bit lanes or above 63 for 64-bit lanes, every active result bit is 0. With `wide_mode`=1 this covers all 128 bits.
- R4: A register count uses `cnt_src[63:0]` as a full 64-bit unsigned value, so any set bit in [63:6] counts toward over-range. `cnt_src[127:64]` has no effect on the result.
- R5: The immediate is zero-extended to 64 bits before the range test. An immediate of 0xFF clears the result for every element size.
- R6: With `wide_mode`=0, `result[127:64]` equals `dst[127:64]`. Only the low 64 bits are shifted or cleared, which gives 4, 2 or 1 lanes.
- R7: Any opcode outside the six listed in R1 sets `illegal`=1 and makes `result` equal `dst`. A legal opcode gives `illegal`=0.
- R8: `out_valid` and `result` appear one clock after `in_valid`. When `in_valid` is 0, `out_valid` falls at the next edge and `result` holds its value.
- R9: While `rst_n` is low, `out_valid` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| opcode | input | 8 | Form-select byte |
| wide_mode | input | 1 | 1 = 128-bit datapath, 0 = 64-bit datapath |
| imm | input | 8 | Immediate count |
| cnt_src | input | 128 | Register count operand; only bits [63:0] are used |
| dst | input | 128 | Operand to shift |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Shifted operand |
| illegal | output | 1 | Opcode not recognised |

## Verification
The over-range clear and the 64-bit mode pass-through act in the same cycle whenever a narrow operation carries an excessive count. In that case the low half must become zero while the high half keeps the destination bits. The bench provokes this by sweeping the count from 0 to 70 for every opcode with `wide_mode` at 0 and at 1. It uses destination patterns whose upper and lower halves differ, and judges every bit against a bench model that works lane by lane and bit by bit. Register counts are applied with garbage in `cnt_src[127:64]` and with isolated high bits set in [63:6], so both the ignored half and the full-width range test are exercised.

// File: rtl/simd_lsr_pkg.sv
package simd_lsr_pkg;

  typedef enum logic [1:0] {
    ESZ_NONE = 2'd0,
    ESZ_W16  = 2'd1,
    ESZ_W32  = 2'd2,
    ESZ_W64  = 2'd3
  } esize_e;

  typedef struct packed {
    logic   legal;
    logic   from_imm;
    esize_e esize;
  } lsr_ctrl_t;

  localparam int unsigned LANE_MIN_W = 16;
  localparam int unsigned LANE_SIZES = 3;
  localparam int unsigned AMT_W      = 6;

endpackage

// File: rtl/lsr_opcode_decode.sv
module lsr_opcode_decode
  import simd_lsr_pkg::*;
(
  input  logic [7:0] opcode,
  output lsr_ctrl_t  ctrl
);

  logic grp_ok;
  logic from_imm;

  always_comb begin
    grp_ok   = 1'b0;
    from_imm = 1'b0;
    case (opcode[7:4])
      4'h7: begin grp_ok = 1'b1; from_imm = 1'b1; end
      4'hD: begin grp_ok = 1'b1; from_imm = 1'b0; end
      default: begin grp_ok = 1'b0; from_imm = 1'b0; end
    endcase
  end

  always_comb begin
    ctrl = '{legal: 1'b0, from_imm: 1'b0, esize: ESZ_NONE};
    if (grp_ok && (opcode[3:2] == 2'b00) && (opcode[1:0] != 2'b00)) begin
      ctrl.legal    = 1'b1;
      ctrl.from_imm = from_imm;
      ctrl.esize    = esize_e'(opcode[1:0]);
    end
  end

endmodule

// File: rtl/lsr_count_sel.sv
module lsr_count_sel
  import simd_lsr_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned IMM_W = 8
) (
  input  logic               from_imm,
  input  logic [IMM_W-1:0]   imm,
  input  logic [CNT_W-1:0]   reg_cnt,
  input  esize_e             esize,
  output logic [AMT_W-1:0]   amt,
  output logic               clear
);

  localparam int unsigned LOG16 = $clog2(LANE_MIN_W);
  localparam int unsigned LOG32 = LOG16 + 1;
  localparam int unsigned LOG64 = LOG16 + 2;

  logic [CNT_W-1:0] cnt;
  logic             over16, over32, over64;

  always_comb begin
    cnt    = from_imm ? CNT_W'(imm) : reg_cnt;
    over16 = |cnt[CNT_W-1:LOG16];
    over32 = |cnt[CNT_W-1:LOG32];
    over64 = |cnt[CNT_W-1:LOG64];
    amt    = cnt[AMT_W-1:0];
    case (esize)
      ESZ_W16: clear = over16;
      ESZ_W32: clear = over32;
      ESZ_W64: clear = over64;
      default: clear = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsr_lane_shifter.sv
module lsr_lane_shifter
  import simd_lsr_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  input  esize_e            esize,
  output logic [DATA_W-1:0] dout
);

  logic [LANE_SIZES-1:0][DATA_W-1:0] cand;

  for (genvar s = 0; s < LANE_SIZES; s++) begin : g_size
    localparam int unsigned LW  = LANE_MIN_W << s;
    localparam int unsigned LSB = $clog2(LW);
    localparam int unsigned NL  = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign cand[s][l*LW +: LW] = din[l*LW +: LW] >> amt[LSB-1:0];
    end
  end

  always_comb begin
    case (esize)
      ESZ_W16: dout = cand[0];
      ESZ_W32: dout = cand[1];
      ESZ_W64: dout = cand[2];
      default: dout = din;
    endcase
  end

endmodule

// File: rtl/simd_lsr_unit.sv
module simd_lsr_unit
  import simd_lsr_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic              wide_mode,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] cnt_src,
  input  logic [DATA_W-1:0] dst,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  localparam int unsigned HALF_W = DATA_W / 2;

  lsr_ctrl_t         ctrl;
  logic [AMT_W-1:0]  amt;
  logic              clear;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] res_nxt;
  logic              ill_nxt;
  logic              vld_nxt;

  lsr_opcode_decode u_dec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  lsr_count_sel #(.CNT_W(CNT_W), .IMM_W(IMM_W)) u_cnt (
    .from_imm (ctrl.from_imm),
    .imm      (imm),
    .reg_cnt  (cnt_src[CNT_W-1:0]),
    .esize    (ctrl.esize),
    .amt      (amt),
    .clear    (clear)
  );

  lsr_lane_shifter #(.DATA_W(DATA_W)) u_shf (
    .din   (dst),
    .amt   (amt),
    .esize (ctrl.esize),
    .dout  (shifted)
  );

  // next-state
  always_comb begin
    vld_nxt = in_valid;
    ill_nxt = in_valid & ~ctrl.legal;
    res_nxt = result;
    if (in_valid) begin
      if (!ctrl.legal) begin
        res_nxt = dst;
      end else begin
        res_nxt[HALF_W-1:0] = clear ? '0 : shifted[HALF_W-1:0];
        if (wide_mode) begin
          res_nxt[DATA_W-1:HALF_W] = clear ? '0 : shifted[DATA_W-1:HALF_W];
        end else begin
          res_nxt[DATA_W-1:HALF_W] = dst[DATA_W-1:HALF_W];
        end
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= vld_nxt;
      illegal   <= ill_nxt;
    end
  end

  // data register, enabled by a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (in_valid) begin
      result <= res_nxt;
    end
  end

endmodule

// File: rtl/simd_lsr_unit_chk.sv
module simd_lsr_unit_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IMM_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic              wide_mode,
  input logic [IMM_W-1:0]  imm,
  input logic [DATA_W-1:0] dst,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic op_ok;
  logic op_imm;
  assign op_imm = (opcode == 8'h71) || (opcode == 8'h72) || (opcode == 8'h73);
  assign op_ok  = op_imm || (opcode == 8'hD1) || (opcode == 8'hD2) || (opcode == 8'hD3);

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  // R7
  bad_op_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_ok) |=> (illegal && result == $past(dst)));

  // R7
  good_op_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok) |=> !illegal);

  // R6
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok && !wide_mode) |=> (result[DATA_W-1:HALF_W] == $past(dst[DATA_W-1:HALF_W])));

  // R5
  imm_max_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_imm && wide_mode && imm == '1) |=> (result == '0));

  // R9
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!out_valid && !illegal);
    end
  end

endmodule

bind simd_lsr_unit simd_lsr_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .wide_mode (wide_mode),
  .imm       (imm),
  .dst       (dst),
  .out_valid (out_valid),
  .result    (result),
  .illegal   (illegal)
);

// File: tb/simd_lsr_unit_bench.sv
module simd_lsr_unit_bench;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [7:0]   opcode;
  logic         wide_mode;
  logic [7:0]   imm;
  logic [127:0] cnt_src;
  logic [127:0] dst;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  simd_lsr_unit u_simd_lsr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .wide_mode(wide_mode), .imm(imm), .cnt_src(cnt_src), .dst(dst),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int lane_w(input logic [7:0] op);
    case (op)
      8'h71, 8'hD1: return 16;
      8'h72, 8'hD2: return 32;
      8'h73, 8'hD3: return 64;
      default:      return 0;
    endcase
  endfunction

  function automatic logic [127:0] model(input logic [7:0] op, input logic w,
      input logic [7:0] im, input logic [127:0] src, input logic [127:0] d);
    logic [127:0] r;
    logic [63:0]  c;
    int ew, nb;
    ew = lane_w(op);
    r  = d;
    if (ew == 0) return d;
    c  = (op[7:4] == 4'h7) ? {56'd0, im} : src[63:0];
    nb = w ? 128 : 64;
    for (int i = 0; i < nb; i++) begin
      int ln, b;
      ln = i / ew;
      b  = i % ew;
      if (c > 64'(ew - 1)) r[i] = 1'b0;
      else if (64'(b) + c < 64'(ew)) r[i] = d[ln*ew + b + int'(c)];
      else r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [7:0] op, input logic w,
      input logic [7:0] im, input logic [127:0] src, input logic [127:0] d);
    logic [127:0] exp;
    @(negedge clk);
    in_valid = 1'b1; opcode = op; wide_mode = w; imm = im; cnt_src = src; dst = d;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(op, w, im, src, d);
    check({tag, " result"}, result, exp);
    check({tag, " illegal"}, {127'd0, illegal}, {127'd0, (lane_w(op) == 0)});
    check("R8 out_valid", {127'd0, out_valid}, 128'd1);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] pats [3];
    logic [7:0]   ops  [6];
    logic [127:0] held;
    pats[0] = {128{1'b1}};
    pats[1] = 128'h8001_7FFE_C003_3FFC_F00F_0FF0_A5A5_5A5A;
    pats[2] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    ops[0] = 8'h71; ops[1] = 8'h72; ops[2] = 8'h73;
    ops[3] = 8'hD1; ops[4] = 8'hD2; ops[5] = 8'hD3;

    rst_n = 1'b0; in_valid = 1'b0; opcode = 8'h00; wide_mode = 1'b1;
    imm = 8'h00; cnt_src = '0; dst = '0;
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", {127'd0, out_valid}, 128'd0);
    check("R9 illegal in reset", {127'd0, illegal}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after release", {127'd0, out_valid}, 128'd0);

    // R1 R2 R3 R6 sweep: counts straddling every lane width, both widths
    for (int o = 0; o < 6; o++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c <= 70; c++)
          for (int p = 0; p < 3; p++)
            if (ops[o][7:4] == 4'h7)
              run_op("R1 R2 R3 R6 imm", ops[o], w[0], 8'(c), ~128'd0, pats[p]);
            else
              run_op("R1 R2 R3 R6 R4 reg", ops[o], w[0], 8'hFF,
                     {64'hDEAD_BEEF_0BAD_F00D, 64'(c)}, pats[p]);

    // R4: each high bit of the 64-bit count forces a clear
    for (int b = 6; b < 64; b++)
      run_op("R4 high count bit", 8'hD2, 1'b1, 8'h00, {64'd0, 64'd1 << b} | 128'd3, pats[2]);
    // R4: upper half of the count operand is ignored
    run_op("R4 upper ignored", 8'hD1, 1'b1, 8'h00, {64'hFFFF_FFFF_FFFF_FFFF, 64'd4}, pats[1]);

    // R5: immediate 0xFF clears for every size and width
    for (int o = 0; o < 3; o++)
      for (int w = 0; w < 2; w++)
        run_op("R5 imm 0xFF", ops[o], w[0], 8'hFF, '0, pats[0]);

    // R7: every opcode outside the six legal ones
    for (int op = 0; op < 256; op++)
      if (lane_w(8'(op)) == 0)
        run_op("R7 illegal opcode", 8'(op), op[0], 8'd3, 128'd3, pats[op % 3]);

    // R8: idle cycle drops out_valid and holds result
    run_op("R8 setup", 8'h72, 1'b1, 8'd5, '0, pats[2]);
    held = result;
    @(negedge clk);
    dst = ~pats[2];
    @(negedge clk);
    check("R8 out_valid drop", {127'd0, out_valid}, 128'd0);
    check("R8 result hold", result, held);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule